// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two 4-bit unsigned operands one bit position per clock cycle. It starts with the least significant position. A one-cycle start pulse captures both operands and begins the run. The datapath then feeds one bit of each captured operand, together with a carry, into a single full adder on every cycle. Each new sum bit enters the top of a right-shifting result register, and the full adder's carry goes into a flip-flop that the next position reads.

A small controller sequences the datapath. It has an idle state, four step states and a done state. In each step it drives a 2-bit position index, a carry-in selector, a shift enable for the result register and a clock enable for the carry flip-flop. The first step selects a carry-in of zero. The later steps select the stored carry. After the fourth step, the result register holds the 4-bit sum and the carry flip-flop holds the final carry-out.

Top module: `serial_add`

## Requirements
- R1: While rst_ni is low, and after it is released, sum_o is 0000, cout_o is 0 and done_o is 0 until a start is accepted.
- R2: A start_i sampled high in idle captures a_i and b_i. Changes on a_i or b_i after that capture do not affect the result.
- R3: Sum bits are produced least significant first, one per cycle. Each bit enters sum_o[3] while the older bits move one place toward sum_o[0]. For 0110 plus 1100, sum_o reads 0000, 1000, 0100, 0010 and cout_o reads 0, 0, 1, 1 after steps 1 to 4.
- R4: In step k (k = 0..3), the position index equals k. The carry-in selector is 0 in step 0 and 1 in steps 1 to 3. The shift enable and the carry clock enable are high only in step states.
- R5: When done_o is high, sum_o equals (a + b) mod 16 and cout_o equals bit 4 of a + b, for every pair of 4-bit operands.
- R6: done_o is high for exactly one cycle. That cycle follows the fourth step, which is the fifth rising edge counted from the edge that samples start_i.
- R7: sum_o and cout_o hold their values in idle and done, until the next accepted start.
- R8: start_i is ignored in the step states and in the done state. The run continues unchanged and no extra done_o pulse follows.
- R9: The first step uses a carry-in of zero whatever carry the previous run left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in idle only |
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| sum_o | output | 4 | Result shift register |
| cout_o | output | 1 | Stored carry, the final carry-out after step 4 |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench sweeps all 256 operand pairs. It runs them back to back, so every run that ends with a carry-out is directly followed by another run. A design that seeds the first step with the stale carry therefore gives wrong sums, and one that indexes the operand bits in the wrong order or shifts in the wrong direction gives a scrambled sum. A start pulse placed mid-run and another during the done cycle would restart the sequence or give a second done pulse if the controller did not ignore them. Operands changed after capture would show up in the result if the design read its inputs live instead of from latched registers.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STEP0 = 3'd1,
    ST_STEP1 = 3'd2,
    ST_STEP2 = 3'd3,
    ST_STEP3 = 3'd4,
    ST_DONE  = 3'd5
  } sa_state_e;

  typedef struct packed {
    logic       load;
    logic [1:0] sel;
    logic       cin_sel;
    logic       shift;
    logic       ce;
  } sa_ctrl_t;
endpackage

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl
  import serial_add_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output sa_ctrl_t  ctrl_o,
  output logic      done_o
);
  sa_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_STEP0;
      ST_STEP0: state_d = ST_STEP1;
      ST_STEP1: state_d = ST_STEP2;
      ST_STEP2: state_d = ST_STEP3;
      ST_STEP3: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.load    = (state_q == ST_IDLE) && start_i;
    unique case (state_q)
      ST_STEP0: ctrl_o.sel = 2'd0;
      ST_STEP1: ctrl_o.sel = 2'd1;
      ST_STEP2: ctrl_o.sel = 2'd2;
      ST_STEP3: ctrl_o.sel = 2'd3;
      default:  ctrl_o.sel = 2'd0;
    endcase
    ctrl_o.shift   = (state_q inside {ST_STEP0, ST_STEP1, ST_STEP2, ST_STEP3});
    ctrl_o.ce      = ctrl_o.shift;
    // first step forces carry-in low
    ctrl_o.cin_sel = (state_q inside {ST_STEP1, ST_STEP2, ST_STEP3});
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/serial_add_bitmux.sv
module serial_add_bitmux #(
  parameter int WIDTH = 4,
  localparam int IdxW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  input  logic [IdxW-1:0]  idx_i,
  output logic             bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < WIDTH; i++)
      if (idx_i == IdxW'(i)) bit_o = vec_i[i];
  end
endmodule

// File: rtl/serial_add_dp.sv
module serial_add_dp
  import serial_add_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sa_ctrl_t         ctrl_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] a_q, b_q, sum_q;
  logic             carry_q, a_bit, b_bit, cin, s_bit, c_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ctrl_i.load) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  serial_add_bitmux #(.WIDTH(WIDTH)) u_mux_a (.vec_i(a_q), .idx_i(ctrl_i.sel), .bit_o(a_bit));
  serial_add_bitmux #(.WIDTH(WIDTH)) u_mux_b (.vec_i(b_q), .idx_i(ctrl_i.sel), .bit_o(b_bit));

  assign cin   = ctrl_i.cin_sel ? carry_q : 1'b0;
  assign s_bit = a_bit ^ b_bit ^ cin;
  assign c_bit = (a_bit & b_bit) | (cin & (a_bit ^ b_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        carry_q <= 1'b0;
    else if (ctrl_i.ce) carry_q <= c_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sum_q <= '0;
    else if (ctrl_i.shift) sum_q <= {s_bit, sum_q[WIDTH-1:1]};
  end

  assign sum_o   = sum_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/serial_add.sv
module serial_add
  import serial_add_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [3:0] sum_o,
  output logic       cout_o,
  output logic       done_o
);
  sa_ctrl_t ctrl;

  serial_add_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ctrl_o (ctrl),
    .done_o (done_o)
  );

  serial_add_dp #(.WIDTH(4)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .carry_o(cout_o)
  );
endmodule

// File: rtl/serial_add_chk.sv
module serial_add_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_o,
  input logic [3:0] sum_o,
  input logic       cout_o,
  input logic [1:0] sel,
  input logic       cin_sel,
  input logic       shift,
  input logic       ce
);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && sel == 2'd3) |=> done_o);
  // R4
  first_cin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && sel == 2'd0) |-> !cin_sel);
  // R4
  later_cin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && sel != 2'd0) |-> cin_sel);
  // R4
  sel_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && sel != 2'd3) |=> (shift && sel == $past(sel) + 2'd1));
  // R4
  ce_in_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ce && !shift));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift |=> ($stable(sum_o) && $stable(cout_o)));
endmodule

bind serial_add serial_add_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .done_o (done_o),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .sel    (ctrl.sel),
  .cin_sel(ctrl.cin_sel),
  .shift  (ctrl.shift),
  .ce     (ctrl.ce)
);

// File: tb/serial_add_test.sv
module serial_add_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] a = '0, b = '0;
  logic [3:0] sum;
  logic       cout, done;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  serial_add uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .sum_o(sum), .cout_o(cout), .done_o(done)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // start pulse then four steps; checks done timing and result
  task automatic run_add(input logic [3:0] x, input logic [3:0] y, input bit scramble);
    logic [4:0] ref_v = {1'b0, x} + {1'b0, y};
    @(negedge clk); start = 1'b1; a = x; b = y;
    @(negedge clk); start = 1'b0;
    if (scramble) begin a = ~x; b = y + 4'd5; end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) check("R6 early done", 6'(done), 6'd0);
    end
    @(negedge clk);
    check("R6 done", 6'(done), 6'd1);
    check(scramble ? "R2 sum" : "R5 sum", 6'(sum), 6'(ref_v[3:0]));
    check(scramble ? "R2 cout" : "R5 cout", 6'(cout), 6'(ref_v[4]));
    @(negedge clk);
    check("R6 done drop", 6'(done), 6'd0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] keep_s;
    logic       keep_c;
    repeat (2) @(negedge clk);
    check("R1 sum", 6'(sum), 6'd0);
    check("R1 cout", 6'(cout), 6'd0);
    check("R1 done", 6'(done), 6'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sum after release", 6'(sum), 6'd0);
    check("R1 done after release", 6'(done), 6'd0);

    // R3 trace
    @(negedge clk); start = 1'b1; a = 4'b0110; b = 4'b1100;
    @(negedge clk); start = 1'b0;
    @(negedge clk); check("R3 s1", {cout, 1'b0, sum}, {1'b0, 1'b0, 4'b0000});
    @(negedge clk); check("R3 s2", {cout, 1'b0, sum}, {1'b0, 1'b0, 4'b1000});
    @(negedge clk); check("R3 s3", {cout, 1'b0, sum}, {1'b1, 1'b0, 4'b0100});
    @(negedge clk); check("R3 s4", {cout, 1'b0, sum}, {1'b1, 1'b0, 4'b0010});
    check("R6 trace done", 6'(done), 6'd1);

    // R9: previous run left carry 1
    run_add(4'd0, 4'd0, 1'b0);
    check("R9 cin zero", {cout, 1'b0, sum}, 6'd0);

    // R5 exhaustive, back to back
    for (int i = 0; i < 256; i++) run_add(4'(i >> 4), 4'(i), 1'b0);

    // R2 operands changed after capture
    for (int i = 0; i < 16; i++) run_add(4'(i), 4'(15 - i + (i & 3)), 1'b1);

    // R7 hold in idle
    run_add(4'd9, 4'd8, 1'b0);
    keep_s = sum; keep_c = cout;
    a = 4'd3; b = 4'd3;
    repeat (4) @(negedge clk);
    check("R7 hold sum", 6'(sum), 6'(keep_s));
    check("R7 hold cout", 6'(cout), 6'(keep_c));

    // R8 start mid-run and during done
    @(negedge clk); start = 1'b1; a = 4'd7; b = 4'd6;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; a = 4'd1; b = 4'd1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R8 no early done", 6'(done), 6'd0);
    @(negedge clk);
    check("R8 done", 6'(done), 6'd1);
    check("R8 sum", 6'(sum), 6'd13);
    start = 1'b1; a = 4'd2; b = 4'd2;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check("R8 no second done", 6'(done), 6'd0);
      @(negedge clk);
    end
    check("R8 sum kept", 6'(sum), 6'd13);
    check("R8 cout kept", 6'(cout), 6'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule